// File: doc/BRIEF.md
# Masked Fixed-Priority Interrupt Arbiter

This block merges the interrupt requests of several peripherals into the single interrupt input of a processor. A request counts only when its channel's mask bit is set and the global enable is on. When any request counts, the arbiter raises the processor's interrupt line. The processor answers by raising its acknowledge input. On the first clock edge that sees the acknowledge high, the arbiter picks the lowest-numbered channel whose request counts and holds that choice until the acknowledge drops. While it holds the choice, it acknowledges that peripheral and drives the channel's software-programmed 8-bit jump-table index onto the vector bus.

Software sets the block up through a small memory-mapped register file at fixed addresses (16-bit address, 8-bit data):

| Register | Address | Meaning |
|---|---|---|
| Mask | 0xFFF0 | Bit i enables channel i; writing 0x03 enables both channels |
| Channel 0 index | 0xFFF1 | Jump-table index for channel 0 |
| Channel 1 index | 0xFFF2 | Jump-table index for channel 1 |
| Global enable | 0xFFF3 | Interrupts are on only while bit 0 is 1 |

Register reads are combinational and return the stored values. No part of this block carries a data stream, so every port is a plain level signal and there is no valid/ready handshake and no back-pressure.

Top module: `intr_prio_arbiter`

## Requirements
- R1: After reset, the mask, both index registers and the enable register read 0. A write to 0xFFF0, 0xFFF1, 0xFFF2 or 0xFFF3 lands on the next rising edge, and a read of that address then returns the full 8-bit value written.
- R2: A write to any address other than 0xFFF0 to 0xFFF3 changes no register. A read of such an address returns 0.
- R3: With bit 0 of the enable register set, `cpu_int` equals the OR over channels of (request bit i AND mask bit i). This holds combinationally in the same cycle.
- R4: While bit 0 of the enable register is 0, `cpu_int` stays low whatever the requests and mask are. An acknowledge in that state grants no channel.
- R5: On the first rising edge at which `cpu_inta` is sampled high after being low, the arbiter latches the lowest-numbered channel whose request counts. Channel 0 beats channel 1. From the next cycle on, and while `cpu_inta` stays high, `periph_ack` is one-hot on that channel. Two ack bits are never high together.
- R6: While `cpu_inta` stays high, the latched grant does not change, even if the requests or the mask change. `periph_ack` goes to 0 in the same cycle that `cpu_inta` goes low.
- R7: While a grant is held and `cpu_inta` is high, `vec_drive` is 1 and `vec_data` equals the granted channel's index register. At all other times `vec_drive` is 0 and `vec_data` is 0.
- R8: If no request counts at the edge where the acknowledge is latched, that acknowledge gets no ack bit and `vec_drive` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register address |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| periph_req | input | 2 | Interrupt request per channel |
| periph_ack | output | 2 | Acknowledge per channel, one-hot or zero |
| cpu_int | output | 1 | Merged interrupt to the processor |
| cpu_inta | input | 1 | Interrupt acknowledge from the processor |
| vec_data | output | 8 | Index of the granted channel |
| vec_drive | output | 1 | High while `vec_data` should be driven onto the shared bus |

## Verification
The bench tries every combination of the four request patterns and the four mask values with the block enabled. This separates correct masking from simple OR-ing of the requests, and it shows whether channel 0 really wins ties. The same requests are then applied with the enable off and with only a high enable bit set, to show that bit 0 alone gates the interrupt. Each acknowledge is followed by raising both requests in mid-handshake and then dropping the acknowledge, which separates a latched grant from one that is re-evaluated every cycle. Register writes aimed just below, just above and far away from the register window tell a full address decode from a partial one.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
  localparam int IDX_W  = 8;
  localparam int ADDR_W = 16;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/intarb_regs.sv
module intarb_regs
  import intarb_pkg::*;
#(
  parameter int                NUM_CH = 2,
  parameter logic [ADDR_W-1:0] BASE   = 16'hFFF0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  idx_t                        wdata,
  output idx_t                        rdata,
  output logic [NUM_CH-1:0]           mask_o,
  output logic [NUM_CH-1:0][IDX_W-1:0] idx_o,
  output logic                        glb_en_o
);
  localparam int OFF_MASK = 0;
  localparam int OFF_IDX0 = 1;
  localparam int OFF_EN   = OFF_IDX0 + NUM_CH;
  localparam int NUM_REG  = OFF_EN + 1;

  logic [ADDR_W-1:0] off;
  logic              in_win;
  idx_t              mask_q, en_q;
  idx_t              idx_q [NUM_CH];

  assign off    = addr - BASE;
  assign in_win = (addr >= BASE) && (off < ADDR_W'(NUM_REG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= '0;
    end else if (wr_en && in_win) begin
      if (off == ADDR_W'(OFF_MASK)) mask_q <= wdata;
      if (off == ADDR_W'(OFF_EN))   en_q   <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_idx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        idx_q[i] <= '0;
      else if (wr_en && in_win && off == ADDR_W'(OFF_IDX0 + i))
        idx_q[i] <= wdata;
    end
    assign idx_o[i] = idx_q[i];
  end

  always_comb begin
    rdata = '0;
    if (in_win) begin
      if (off == ADDR_W'(OFF_MASK)) rdata = mask_q;
      if (off == ADDR_W'(OFF_EN))   rdata = en_q;
      for (int i = 0; i < NUM_CH; i++)
        if (off == ADDR_W'(OFF_IDX0 + i)) rdata = idx_q[i];
    end
  end

  assign mask_o   = mask_q[NUM_CH-1:0];
  assign glb_en_o = en_q[0];

  // R2: a write outside the window leaves the mask and enable untouched
  a_r2_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_win) |=> ($stable(mask_q) && $stable(en_q)));
  // R1: a write to the mask address lands on the next edge
  a_r1_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == BASE) |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/intarb_pick.sv
module intarb_pick #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] elig,
  output logic [NUM_CH-1:0] winner
);
  always_comb begin
    winner = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (elig[i]) winner = NUM_CH'(1) << i;
  end

  // R5: the winner is one-hot whenever any channel counts
  a_r5_pick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> ($countones(winner) == 1 && (winner & ~elig) == '0));
endmodule

// File: rtl/intarb_ack.sv
module intarb_ack #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_inta,
  input  logic [NUM_CH-1:0] winner,
  output logic [NUM_CH-1:0] grant,
  output logic              busy
);
  logic              inta_q;
  logic [NUM_CH-1:0] grant_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inta_q  <= 1'b0;
      grant_q <= '0;
    end else begin
      inta_q <= cpu_inta;
      if (!cpu_inta)
        grant_q <= '0;
      else if (!inta_q)
        grant_q <= winner;
    end
  end

  assign grant = grant_q & {NUM_CH{cpu_inta}};
  assign busy  = cpu_inta && (|grant_q);

  // R6: the grant stays fixed through a continuing acknowledge
  a_r6_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_inta && inta_q) |=> (!cpu_inta || $stable(grant_q)));
  // R5: at most one channel is acknowledged
  a_r5_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R6: with the acknowledge low, nothing is granted
  a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_inta |=> (grant_q == '0));
endmodule

// File: rtl/intr_prio_arbiter.sv
module intr_prio_arbiter
  import intarb_pkg::*;
#(
  parameter int                NUM_CH = 2,
  parameter logic [ADDR_W-1:0] BASE   = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              bus_wr_en,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NUM_CH-1:0] periph_req,
  output logic [NUM_CH-1:0] periph_ack,
  output logic              cpu_int,
  input  logic              cpu_inta,
  output logic [7:0]        vec_data,
  output logic              vec_drive
);
  logic [NUM_CH-1:0]            mask, elig, winner, grant;
  logic [NUM_CH-1:0][IDX_W-1:0] idx;
  logic                         glb_en, busy;

  intarb_regs #(.NUM_CH(NUM_CH), .BASE(BASE)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .mask_o(mask), .idx_o(idx),
    .glb_en_o(glb_en)
  );

  assign elig    = periph_req & mask & {NUM_CH{glb_en}};
  assign cpu_int = |elig;

  intarb_pick #(.NUM_CH(NUM_CH)) i_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .winner(winner)
  );

  intarb_ack #(.NUM_CH(NUM_CH)) i_ack (
    .clk(clk), .rst_n(rst_n), .cpu_inta(cpu_inta), .winner(winner),
    .grant(grant), .busy(busy)
  );

  always_comb begin
    vec_data = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (grant[i]) vec_data = vec_data | idx[i];
  end

  assign periph_ack = grant;
  assign vec_drive  = busy;

  // R4: no interrupt while the global enable bit is clear
  a_r4_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !cpu_int);
  // R7: the vector is only driven inside an acknowledge
  a_r7_drive_in_inta: assert property (@(posedge clk) disable iff (!rst_n)
    vec_drive |-> (cpu_inta && $onehot(periph_ack)));
  // R7: a released vector bus carries zero
  a_r7_released_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_drive |-> (vec_data == '0));
endmodule

// File: tb/test_intr_prio_arbiter.sv
module test_intr_prio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] periph_req = '0;
  logic [1:0] periph_ack;
  logic       cpu_int;
  logic       cpu_inta = 1'b0;
  logic [7:0] vec_data;
  logic       vec_drive;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intr_prio_arbiter i_intr_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_req(periph_req),
    .periph_ack(periph_ack), .cpu_int(cpu_int), .cpu_inta(cpu_inta),
    .vec_data(vec_data), .vec_drive(vec_drive)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input int exp);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, "readback", int'(bus_rdata), exp);
  endtask

  // one acknowledge handshake; expected values from mask, request and index
  task automatic handshake(input string req, input logic [1:0] elig,
                           input logic [7:0] ix0, input logic [7:0] ix1);
    int exp_ack, exp_vec, exp_drv;
    exp_ack = elig[0] ? 1 : (elig[1] ? 2 : 0);
    exp_vec = elig[0] ? int'(ix0) : (elig[1] ? int'(ix1) : 0);
    exp_drv = (elig != 2'b00) ? 1 : 0;
    @(negedge clk);
    cpu_inta = 1'b1;
    #1 chk("R5", "ack before latch", int'(periph_ack), 0);
    @(negedge clk);
    #1;
    chk(req, "ack", int'(periph_ack), exp_ack);
    chk("R7", "vec_data", int'(vec_data), exp_vec);
    chk("R7", "vec_drive", int'(vec_drive), exp_drv);
    @(negedge clk);
    periph_req = 2'b11;                      // late request mid-handshake
    @(negedge clk);
    #1 chk("R6", "ack held", int'(periph_ack), exp_ack);
    chk("R6", "vec held", int'(vec_data), exp_vec);
    @(negedge clk);
    cpu_inta = 1'b0;
    #1 chk("R6", "ack drop", int'(periph_ack), 0);
    chk("R7", "released drive", int'(vec_drive), 0);
    chk("R7", "released data", int'(vec_data), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 4; a++) rd_chk("R1", 16'hFFF0 + 16'(a), 0);
    #1 chk("R1", "int after reset", int'(cpu_int), 0);
    chk("R1", "ack after reset", int'(periph_ack), 0);
    chk("R7", "drive after reset", int'(vec_drive), 0);
    // R1: writes and readback
    wr(16'hFFF1, 8'h0D);
    wr(16'hFFF2, 8'h11);
    wr(16'hFFF0, 8'h03);
    rd_chk("R1", 16'hFFF0, 8'h03);
    rd_chk("R1", 16'hFFF1, 8'h0D);
    rd_chk("R1", 16'hFFF2, 8'h11);
    rd_chk("R1", 16'hFFF3, 0);
    // R2: stray writes are ignored
    wr(16'hFFEF, 8'hFF);
    wr(16'hFFF4, 8'hFF);
    wr(16'h0000, 8'hFF);
    wr(16'h7FF3, 8'hFF);
    rd_chk("R2", 16'hFFF0, 8'h03);
    rd_chk("R2", 16'hFFF1, 8'h0D);
    rd_chk("R2", 16'hFFF2, 8'h11);
    rd_chk("R2", 16'hFFF3, 0);
    rd_chk("R2", 16'hFFF4, 0);
    rd_chk("R2", 16'hFFEF, 0);
    // R4: global enable off, then only a high bit set
    for (int e = 0; e < 2; e++) begin
      if (e == 1) wr(16'hFFF3, 8'hFE);
      for (int r = 0; r < 4; r++) begin
        @(negedge clk);
        periph_req = 2'(r);
        #1 chk("R4", "int while disabled", int'(cpu_int), 0);
      end
      handshake("R4", 2'b00, 8'h0D, 8'h11);
    end
    // R3, R5, R8: full sweep of mask x request with enable on
    wr(16'hFFF3, 8'h01);
    for (int m = 0; m < 4; m++) begin
      wr(16'hFFF0, 8'(m));
      for (int r = 0; r < 4; r++) begin
        logic [1:0] el;
        el = 2'(m) & 2'(r);
        @(negedge clk);
        periph_req = 2'(r);
        #1 chk("R3", "int merge", int'(cpu_int), (el != 2'b00) ? 1 : 0);
        handshake((el == 2'b00) ? "R8" : "R5", el, 8'h0D, 8'h11);
      end
    end
    // R5: new index values picked up on a tie
    wr(16'hFFF1, 8'hFF);
    wr(16'hFFF2, 8'h00);
    wr(16'hFFF0, 8'h03);
    @(negedge clk);
    periph_req = 2'b11;
    handshake("R5", 2'b11, 8'hFF, 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule